// File: doc/BRIEF.md
# Nibble-to-Byte Multi-Channel Crossing FIFO

This block buffers nibble-wide data captured by I/O logic on its way into core logic, across two unrelated clocks. A write clock domain pushes one 4-bit nibble per channel on each accepted write. A read clock domain pops entries in show-ahead fashion: the head entry is always present on the read bus while the FIFO is not empty. Every channel shares one write pointer and one read pointer, so all lanes advance together. This gives a single full flag in the write domain and a single empty flag in the read domain. Both flags come from gray-coded pointers that cross to the other domain through two-flop synchronizers.

A static mode input selects between two layouts. In nibble mode the FIFO carries twelve 4-bit channels. Ten of them sit in the low nibbles of lanes 0..9, and two more are folded into the high nibbles of lanes 5 and 6. In byte mode the FIFO carries ten channels and combines two consecutive nibble writes into one byte entry on the read side. This suits a write clock that runs at twice the read rate. The mode may only change while both resets are held.

Top module: `nib_byte_fifo`

## Requirements
- R1: After both resets are held together, rd_empty is 1 and wr_full is 0.
- R2: In nibble mode (byte_mode=0), lanes 0..9 carry channels 0..9: read lane n bits [3:0] equal the written lane n bits [3:0]. Read bits [7:4] are 0 on every lane except 5 and 6.
- R3: In nibble mode, channel 10 travels in bits [7:4] of lane 5 and channel 11 in bits [7:4] of lane 6. Both are read back unchanged at the same position.
- R4: In byte mode (byte_mode=1), two accepted writes form one entry. The first write's lane n bits [3:0] land in read bits [3:0] and the second write's lane n bits [3:0] land in read bits [7:4]. Write bits [7:4] are ignored.
- R5: In byte mode a single accepted write does not make an entry visible: rd_empty stays 1 until the second write of the pair.
- R6: Entries are read in write order, including across pointer wrap-around. The read pointer advances by at most one per read clock.
- R7: The FIFO holds 9 entries. wr_full is 1 in the write-clock cycle after the ninth entry is committed, which is 9 writes in nibble mode and 18 in byte mode. It is 0 before that.
- R8: A write while wr_full is 1 is ignored. It changes neither the stored data nor the byte-mode pairing phase.
- R9: A read while rd_empty is 1 is ignored and leaves the read pointer unchanged.
- R10: A committed entry clears rd_empty, and a read frees space that clears wr_full. Each reaches the other domain through a two-stage synchronizer, within three clock edges of that domain. Each synchronized pointer changes by at most one bit per edge.
- R11: While rd_empty is 0, rd_data shows the head entry without a read strobe. A read on a rising rd_clk edge moves to the next entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_mode | input | 1 | Static layout select: 0 nibble mode (12 channels), 1 byte mode (10 channels) |
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 80 | Ten 8-bit write lanes, lane n at bits [8n+7:8n] |
| wr_full | output | 1 | FIFO full, write domain |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read strobe (pop) |
| rd_data | output | 80 | Head entry, ten 8-bit lanes |
| rd_empty | output | 1 | FIFO empty, read domain |

## Verification
wr_full rises combinationally in the same write cycle as the committing edge, so the bench samples it on the next falling write-clock edge. A pop likewise updates rd_empty and rd_data before the following falling read-clock edge. Any flag change caused by the other domain is due only after two synchronizer flops. For those, the bench waits four falling edges of the observing clock before it compares, which covers the worst-case phase between the two clocks. All inputs are driven and all outputs sampled on falling edges, away from the edges where the design updates.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

    localparam int NIB_W  = 4;
    localparam int LANE_W = 8;
    localparam int GW     = 16;

    typedef enum logic {
        MODE_NIB  = 1'b0,
        MODE_BYTE = 1'b1
    } lane_mode_e;

    function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/nbf_sync.sv
module nbf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/nbf_store.sv
module nbf_store #(
    parameter int DW    = 80,
    parameter int DEPTH = 9,
    parameter int AW    = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/nbf_wr_ctrl.sv
module nbf_wr_ctrl
    import nbf_pkg::*;
#(
    parameter int LANES  = 10,
    parameter int DEPTH  = 9,
    parameter int AW     = 4,
    parameter int PW     = 5,
    parameter int FOLD_A = 5,
    parameter int FOLD_B = 6
) (
    input  logic                    wclk,
    input  logic                    wrst,
    input  lane_mode_e              mode,
    input  logic                    wr_en,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [PW-1:0]           rgray_sync,
    output logic                    full,
    output logic                    commit,
    output logic [AW-1:0]           widx,
    output logic [LANES*LANE_W-1:0] wdata,
    output logic [PW-1:0]           wbin,
    output logic [PW-1:0]           wgray
);
    localparam int DW = LANES * LANE_W;

    logic                   phase;
    logic                   accept;
    logic [LANES*NIB_W-1:0] lo_hold;
    logic [LANES*NIB_W-1:0] lo_in;
    logic [DW-1:0]          nib_word;
    logic [DW-1:0]          byte_word;
    logic [PW-1:0]          rsync_bin;
    logic [PW-1:0]          occ;
    logic [PW-1:0]          wbin_nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lo_in[l*NIB_W +: NIB_W]      = wr_data[l*LANE_W +: NIB_W];
        assign byte_word[l*LANE_W +: LANE_W] = {wr_data[l*LANE_W +: NIB_W], lo_hold[l*NIB_W +: NIB_W]};
        if (l == FOLD_A || l == FOLD_B) begin : g_fold
            assign nib_word[l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
        end else begin : g_plain
            logic unused_top;
            assign unused_top = ^wr_data[l*LANE_W+NIB_W +: NIB_W];
            assign nib_word[l*LANE_W +: LANE_W] = {{NIB_W{1'b0}}, wr_data[l*LANE_W +: NIB_W]};
        end
    end

    assign rsync_bin = PW'(gray2bin(GW'(rgray_sync)));
    assign occ       = wbin - rsync_bin;
    assign full      = (occ >= PW'(DEPTH));
    assign accept    = wr_en && !full;
    assign commit    = accept && ((mode == MODE_NIB) || phase);
    assign wdata     = (mode == MODE_BYTE) ? byte_word : nib_word;
    assign wbin_nxt  = wbin + PW'(1);

    always_ff @(posedge wclk) begin
        if (wrst) begin
            phase   <= 1'b0;
            lo_hold <= '0;
            wbin    <= '0;
            wgray   <= '0;
            widx    <= '0;
        end else begin
            if (accept && mode == MODE_BYTE) begin
                phase <= !phase;
                if (!phase) begin
                    lo_hold <= lo_in;
                end
            end
            if (commit) begin
                wbin  <= wbin_nxt;
                wgray <= PW'(bin2gray(GW'(wbin_nxt)));
                widx  <= (widx == AW'(DEPTH - 1)) ? '0 : widx + AW'(1);
            end
        end
    end
endmodule

// File: rtl/nbf_rd_ctrl.sv
module nbf_rd_ctrl
    import nbf_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int AW    = 4,
    parameter int PW    = 5
) (
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_sync,
    output logic          empty,
    output logic [AW-1:0] ridx,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray
);
    logic [PW-1:0] wsync_bin;
    logic [PW-1:0] rbin_nxt;
    logic          pop;

    assign wsync_bin = PW'(gray2bin(GW'(wgray_sync)));
    assign empty     = (rbin == wsync_bin);
    assign pop       = rd_en && !empty;
    assign rbin_nxt  = rbin + PW'(1);

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            ridx  <= '0;
        end else if (pop) begin
            rbin  <= rbin_nxt;
            rgray <= PW'(bin2gray(GW'(rbin_nxt)));
            ridx  <= (ridx == AW'(DEPTH - 1)) ? '0 : ridx + AW'(1);
        end
    end
endmodule

// File: rtl/nib_byte_fifo.sv
module nib_byte_fifo
    import nbf_pkg::*;
#(
    parameter int LANES  = 10,
    parameter int DEPTH  = 9,
    parameter int FOLD_A = 5,
    parameter int FOLD_B = 6
) (
    input  logic                    byte_mode,
    input  logic                    wr_clk,
    input  logic                    wr_rst,
    input  logic                    wr_en,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic                    wr_full,
    input  logic                    rd_clk,
    input  logic                    rd_rst,
    input  logic                    rd_en,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_empty
);
    localparam int DW = LANES * LANE_W;
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = AW + 1;

    lane_mode_e    mode;
    logic          commit;
    logic [AW-1:0] widx;
    logic [AW-1:0] ridx;
    logic [DW-1:0] wdata;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_sync;
    logic [PW-1:0] rgray_sync;

    assign mode = lane_mode_e'(byte_mode);

    nbf_wr_ctrl #(
        .LANES(LANES), .DEPTH(DEPTH), .AW(AW), .PW(PW),
        .FOLD_A(FOLD_A), .FOLD_B(FOLD_B)
    ) u_wr (
        .wclk(wr_clk), .wrst(wr_rst), .mode(mode), .wr_en(wr_en),
        .wr_data(wr_data), .rgray_sync(rgray_sync), .full(wr_full),
        .commit(commit), .widx(widx), .wdata(wdata),
        .wbin(wbin), .wgray(wgray)
    );

    nbf_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .rclk(rd_clk), .rrst(rd_rst), .rd_en(rd_en),
        .wgray_sync(wgray_sync), .empty(rd_empty), .ridx(ridx),
        .rbin(rbin), .rgray(rgray)
    );

    nbf_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_sync)
    );

    nbf_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_sync)
    );

    nbf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(commit), .widx(widx), .wdata(wdata),
        .ridx(ridx), .rdata(rd_data)
    );
endmodule

// File: rtl/nib_byte_fifo_chk.sv
module nib_byte_fifo_chk #(
    parameter int PW = 5
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          byte_mode,
    input logic          wr_en,
    input logic          wr_full,
    input logic          rd_en,
    input logic          rd_empty,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rbin,
    input logic [PW-1:0] rgray
);
    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_full && wr_en) |=> (wbin == $past(wbin)));                        // R8

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_empty && rd_en) |=> (rbin == $past(rbin)));                       // R9

    AST_WGRAY_ONE_STEP: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1);                               // R10

    AST_RGRAY_ONE_STEP: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rgray ^ $past(rgray)) <= 1);                               // R10

    AST_BYTE_PAIRING: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (byte_mode && (wbin != $past(wbin))) |=> (wbin == $past(wbin)));      // R5

    AST_RD_SINGLE_STEP: assert property (@(posedge rd_clk) disable iff (rd_rst)
        PW'(rbin - $past(rbin)) <= PW'(1));                                   // R6
endmodule

bind nib_byte_fifo nib_byte_fifo_chk #(.PW(PW)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .byte_mode(byte_mode), .wr_en(wr_en), .wr_full(wr_full),
    .rd_en(rd_en), .rd_empty(rd_empty),
    .wbin(wbin), .wgray(wgray), .rbin(rbin), .rgray(rgray)
);

// File: tb/nib_byte_fifo_tb.sv
module nib_byte_fifo_tb;
    localparam int LANES = 10;
    localparam int DW    = LANES * 8;
    localparam int DEPTH = 9;
    localparam int NVEC  = 12;

    localparam logic [7:0] SEEDS [NVEC] = '{
        8'h00, 8'h01, 8'h3C, 8'hA5, 8'hFF, 8'h5A,
        8'h12, 8'h7E, 8'h81, 8'hC3, 8'h66, 8'h99
    };

    logic          byte_mode = 1'b0;
    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst = 1'b1;
    logic          rd_rst = 1'b1;
    logic          wr_en  = 1'b0;
    logic          rd_en  = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_full;
    logic          rd_empty;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    always #2.5 wr_clk = ~wr_clk;
    always #5   rd_clk = ~rd_clk;

    nib_byte_fifo u_dut (
        .byte_mode(byte_mode), .wr_clk(wr_clk), .wr_rst(wr_rst),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    function automatic logic [DW-1:0] mk(input logic [7:0] s);
        logic [DW-1:0] w;
        for (int l = 0; l < LANES; l++) begin
            w[l*8 +: 8] = s * 8'd37 + 8'(l) * 8'd11 + 8'h5A;
        end
        return w;
    endfunction

    function automatic logic [DW-1:0] exp_nib(input logic [DW-1:0] w);
        logic [DW-1:0] e;
        for (int l = 0; l < LANES; l++) begin
            if (l == 5 || l == 6) e[l*8 +: 8] = w[l*8 +: 8];
            else                  e[l*8 +: 8] = {4'h0, w[l*8 +: 4]};
        end
        return e;
    endfunction

    function automatic logic [DW-1:0] exp_byte(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] e;
        for (int l = 0; l < LANES; l++) begin
            e[l*8 +: 8] = {b[l*8 +: 4], a[l*8 +: 4]};
        end
        return e;
    endfunction

    task automatic chk_bus(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s rd_data act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge rd_clk);
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        byte_mode = mode;
        repeat (6) @(negedge rd_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic push(input logic [DW-1:0] w);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge wr_clk);
        wr_en   = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [DW-1:0] exp);
        @(negedge rd_clk);
        chk_bus(req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic settle_rd();
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic settle_wr();
        repeat (4) @(negedge wr_clk);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(1'b0);
        chk_bit("R1", "rd_empty", rd_empty, 1'b1);
        chk_bit("R1", "wr_full", wr_full, 1'b0);

        // Vector table: two rounds of six, pointers wrap past the depth (R2 R3 R6 R11)
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 6; i++) push(mk(SEEDS[r*6+i]));
            settle_rd();
            chk_bit("R10", "rd_empty after commit", rd_empty, 1'b0);
            for (int i = 0; i < 6; i++) pop_check("R2_R3_R6", exp_nib(mk(SEEDS[r*6+i])));
        end
        chk_bit("R6", "rd_empty after drain", rd_empty, 1'b1);

        // R9: read on empty is ignored
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        push(mk(8'h4D));
        settle_rd();
        chk_bit("R9", "rd_empty after write", rd_empty, 1'b0);
        pop_check("R9", exp_nib(mk(8'h4D)));

        // R7 R8: fill to depth, overflow write ignored
        settle_wr();
        for (int i = 0; i < DEPTH; i++) begin
            push(mk(8'(8'h20 + i)));
            if (i == DEPTH - 2) chk_bit("R7", "wr_full at 8", wr_full, 1'b0);
        end
        chk_bit("R7", "wr_full at 9", wr_full, 1'b1);
        push(mk(8'hEE));
        settle_rd();
        for (int i = 0; i < DEPTH; i++) pop_check("R8", exp_nib(mk(8'(8'h20 + i))));
        chk_bit("R8", "rd_empty after overflow", rd_empty, 1'b1);
        settle_wr();
        chk_bit("R10", "wr_full cleared", wr_full, 1'b0);

        // Byte mode: pairing and visibility (R4 R5)
        do_reset(1'b1);
        push(mk(8'h11));
        settle_rd();
        chk_bit("R5", "rd_empty after one nibble", rd_empty, 1'b1);
        push(mk(8'h22));
        settle_rd();
        chk_bit("R5", "rd_empty after pair", rd_empty, 1'b0);
        pop_check("R4", exp_byte(mk(8'h11), mk(8'h22)));

        // Byte mode fill: 18 writes to full, extra pair ignored (R7 R8)
        settle_wr();
        for (int i = 0; i < 2*DEPTH; i++) begin
            push(mk(8'(8'h40 + i)));
            if (i == 2*DEPTH - 2) chk_bit("R7", "wr_full at 17 nibbles", wr_full, 1'b0);
        end
        chk_bit("R7", "wr_full at 18 nibbles", wr_full, 1'b1);
        push(mk(8'hD0));
        push(mk(8'hD1));
        settle_rd();
        for (int i = 0; i < DEPTH; i++)
            pop_check("R4_R6", exp_byte(mk(8'(8'h40 + 2*i)), mk(8'(8'h41 + 2*i))));
        chk_bit("R8", "rd_empty after byte overflow", rd_empty, 1'b1);
        settle_wr();
        push(mk(8'h73));
        push(mk(8'h74));
        settle_rd();
        pop_check("R8", exp_byte(mk(8'h73), mk(8'h74)));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule